// File: doc/BRIEF.md
# Thread Interrupt Priority Presenter

This block keeps the operating-system ring interrupt context of a single hardware thread. A router delivers notifications, each carrying a priority from 0 to 7, and every notification marks that priority in an 8-bit pending buffer. The block derives the most favoured pending priority and compares it with a software-programmed current priority threshold. On the smaller number wins. When the pending priority beats the threshold, the block raises the thread interrupt line and flags an OS exception in its notification source register.

Software reaches the context through a management area made of four page views. The two low page-address bits select the view. The OS view is the only one that can change the context. It also carries a special acknowledge load. That load returns the exception state and the pending priority, and it moves the context forward to service that priority. The physical and hypervisor views can only read the OS context. The user view reads as zero and ignores stores.

Top module: `os_irq_presenter`

## Requirements
- R1: A notify pulse with priority p sets bit p of the pending buffer. The buffer reads back at register select 2, in rdata[7:0].
- R2: The pending priority reads at select 3. It is the lowest index whose pending bit is set, or 0xFF when the buffer is empty.
- R3: irq_o is high exactly when, one cycle earlier, the pending priority was numerically below the current priority. A current priority of 0x00 blocks every priority, and 0xFF accepts all of them.
- R4: The notification source register reads at select 0. Bit 7 is the exception flag and always equals irq_o. All other bits read zero.
- R5: A store at select 1 from the OS page (page bits 2'b10) loads the current priority. The interrupt line is re-evaluated against the new value in the next cycle, so it can rise or fall.
- R6: An acknowledge load is select 4 on the OS page. If the exception flag is set, it returns the notification source register in rdata[15:8] and the pending priority in rdata[7:0]. At the same edge it sets the current priority to that pending priority, clears that pending bit, clears the exception flag and drops irq_o.
- R7: An acknowledge load while the exception flag is clear returns 0x00 in rdata[15:8] and the pending priority in rdata[7:0]. It changes no state.
- R8: The physical page (2'b00) and the hypervisor page (2'b01) read selects 0 to 3 like the OS page. Stores from them are ignored. Select 4 on these pages reads zero and has no side effects.
- R9: The user page (2'b11) reads zero for every select, and stores from it are ignored.
- R10: After reset the pending buffer is 0, the current priority is 0x00, and both irq_o and rdata_o are 0.
- R11: If a notify and an acknowledge land in the same cycle on the same priority, the notify wins and the pending bit stays set.
- R12: Selects 5 to 7 read zero on every page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| notify_i | input | 1 | Notification pulse from the router |
| notify_prio_i | input | 3 | Priority of the notification |
| acc_valid_i | input | 1 | Management-area access strobe |
| acc_write_i | input | 1 | 1 = store, 0 = load |
| acc_page_i | input | 2 | Page view select (00 phys, 01 hyp, 10 OS, 11 user) |
| acc_sel_i | input | 3 | Register select within the page |
| acc_wdata_i | input | 8 | Store data |
| rdata_o | output | 16 | Registered load data, updated at the edge that takes the load |
| irq_o | output | 1 | Thread interrupt line |

## Verification
The pending buffer, the current priority and the load data are all updated at the clock edge that takes the notify or access. The bench therefore reads them back at the falling edge that follows. The interrupt line is registered from the comparison, so a notify or a threshold store shows on irq_o one cycle after that edge. The bench waits one idle cycle before it samples irq_o. An acknowledge is the exception: it clears irq_o at its own edge, and the bench checks the line straight after that edge and again after further cycles.

// File: rtl/os_irq_pkg.sv
package os_irq_pkg;
  localparam int unsigned NPRIO    = 8;
  localparam int unsigned PRIO_W   = $clog2(NPRIO);
  localparam int unsigned REG_W    = 8;
  localparam int unsigned SEL_W    = 3;
  localparam int unsigned EO_BIT   = 7;
  localparam logic [REG_W-1:0] PRIO_NONE = '1;

  typedef enum logic [1:0] {
    PG_PHYS = 2'b00,
    PG_HYP  = 2'b01,
    PG_OS   = 2'b10,
    PG_USER = 2'b11
  } page_e;

  typedef enum logic [SEL_W-1:0] {
    SEL_NSR  = 3'd0,
    SEL_CPPR = 3'd1,
    SEL_IPB  = 3'd2,
    SEL_PIPR = 3'd3,
    SEL_ACK  = 3'd4
  } sel_e;
endpackage

// File: rtl/os_irq_page_decode.sv
module os_irq_page_decode
  import os_irq_pkg::*;
(
  input  logic             valid_i,
  input  logic             write_i,
  input  logic [1:0]       page_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             cppr_wr_o,
  output logic             ack_o,
  output logic             rd_o,
  output logic             rd_vis_o
);
  logic os_pg, ro_pg;

  always_comb begin
    os_pg     = (page_i == PG_OS);
    ro_pg     = (page_i == PG_PHYS) || (page_i == PG_HYP);
    cppr_wr_o = valid_i && write_i && os_pg && (sel_i == SEL_CPPR);
    ack_o     = valid_i && !write_i && os_pg && (sel_i == SEL_ACK);
    rd_o      = valid_i && !write_i;
    // plain register view: selects 0..3 on OS or privileged read-only pages
    rd_vis_o  = (os_pg || ro_pg) && (sel_i <= SEL_PIPR);
  end
endmodule

// File: rtl/os_irq_pend_buf.sv
module os_irq_pend_buf
  import os_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic [PRIO_W-1:0] set_prio_i,
  input  logic              clr_i,
  input  logic [PRIO_W-1:0] clr_prio_i,
  output logic [NPRIO-1:0]  ipb_o
);
  logic [NPRIO-1:0] ipb_q, ipb_d;

  always_comb begin
    ipb_d = ipb_q;
    for (int i = 0; i < NPRIO; i++) begin
      if (clr_i && (clr_prio_i == PRIO_W'(i))) ipb_d[i] = 1'b0;
      if (set_i && (set_prio_i == PRIO_W'(i))) ipb_d[i] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ipb_q <= '0;
    else         ipb_q <= ipb_d;
  end

  assign ipb_o = ipb_q;
endmodule

// File: rtl/os_irq_prio_enc.sv
module os_irq_prio_enc
  import os_irq_pkg::*;
(
  input  logic [NPRIO-1:0] ipb_i,
  output logic [REG_W-1:0] pipr_o
);
  logic [NPRIO:0]   hit;
  logic [REG_W-1:0] val [NPRIO+1];

  assign hit[NPRIO] = 1'b0;
  assign val[NPRIO] = PRIO_NONE;

  // chain from least favoured to most favoured; lower index overrides
  for (genvar g = NPRIO - 1; g >= 0; g--) begin : g_chain
    assign hit[g] = ipb_i[g] | hit[g+1];
    assign val[g] = ipb_i[g] ? REG_W'(g) : val[g+1];
  end

  assign pipr_o = val[0];
endmodule

// File: rtl/os_irq_presenter.sv
module os_irq_presenter
  import os_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              notify_i,
  input  logic [2:0]        notify_prio_i,
  input  logic              acc_valid_i,
  input  logic              acc_write_i,
  input  logic [1:0]        acc_page_i,
  input  logic [2:0]        acc_sel_i,
  input  logic [7:0]        acc_wdata_i,
  output logic [15:0]       rdata_o,
  output logic              irq_o
);
  logic             cppr_wr, ack_req, rd_req, rd_vis, ack_fire;
  logic [NPRIO-1:0] ipb_q;
  logic [REG_W-1:0] pipr, cppr_q, nsr;
  logic             eo_q;
  logic [15:0]      rdata_q, rd_val;

  os_irq_page_decode u_dec (
    .valid_i  (acc_valid_i),
    .write_i  (acc_write_i),
    .page_i   (acc_page_i),
    .sel_i    (acc_sel_i),
    .cppr_wr_o(cppr_wr),
    .ack_o    (ack_req),
    .rd_o     (rd_req),
    .rd_vis_o (rd_vis)
  );

  assign ack_fire = ack_req && eo_q;

  os_irq_pend_buf u_ipb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (notify_i),
    .set_prio_i(notify_prio_i),
    .clr_i     (ack_fire),
    .clr_prio_i(pipr[PRIO_W-1:0]),
    .ipb_o     (ipb_q)
  );

  os_irq_prio_enc u_enc (
    .ipb_i (ipb_q),
    .pipr_o(pipr)
  );

  always_comb begin
    nsr         = '0;
    nsr[EO_BIT] = eo_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cppr_q <= '0;
      eo_q   <= 1'b0;
    end else begin
      if (ack_fire)     cppr_q <= pipr;
      else if (cppr_wr) cppr_q <= acc_wdata_i;
      eo_q <= ack_fire ? 1'b0 : (pipr < cppr_q);
    end
  end

  always_comb begin
    rd_val = '0;
    if (ack_req) begin
      rd_val = {nsr, pipr};
    end else if (rd_vis) begin
      unique case (acc_sel_i)
        SEL_NSR:  rd_val = {8'h00, nsr};
        SEL_CPPR: rd_val = {8'h00, cppr_q};
        SEL_IPB:  rd_val = {8'h00, ipb_q};
        SEL_PIPR: rd_val = {8'h00, pipr};
        default:  rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rdata_q <= '0;
    else if (rd_req) rdata_q <= rd_val;
  end

  assign rdata_o = rdata_q;
  assign irq_o   = eo_q;
endmodule

// File: rtl/os_irq_presenter_chk.sv
module os_irq_presenter_chk
  import os_irq_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             notify_i,
  input logic [2:0]       notify_prio_i,
  input logic             acc_valid_i,
  input logic             acc_write_i,
  input logic [1:0]       acc_page_i,
  input logic [2:0]       acc_sel_i,
  input logic [7:0]       acc_wdata_i,
  input logic             irq_o,
  input logic [NPRIO-1:0] ipb,
  input logic [REG_W-1:0] pipr,
  input logic [REG_W-1:0] cppr,
  input logic             ack_fire
);
  assert_notify_sets_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    notify_i |=> ipb[$past(notify_prio_i)]);

  assert_pipr_pending_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ipb != '0) |-> (pipr < REG_W'(NPRIO)) && ipb[pipr[PRIO_W-1:0]]);

  assert_pipr_empty_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ipb == '0) |-> (pipr == PRIO_NONE));

  assert_irq_cause_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(pipr < cppr));

  assert_cppr_store_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && acc_write_i && acc_page_i == PG_OS && acc_sel_i == SEL_CPPR)
      |=> cppr == $past(acc_wdata_i));

  assert_ack_drops_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_fire |=> !irq_o);

  assert_user_store_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && acc_write_i && acc_page_i == PG_USER) |=> $stable(cppr));
endmodule

bind os_irq_presenter os_irq_presenter_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .notify_i     (notify_i),
  .notify_prio_i(notify_prio_i),
  .acc_valid_i  (acc_valid_i),
  .acc_write_i  (acc_write_i),
  .acc_page_i   (acc_page_i),
  .acc_sel_i    (acc_sel_i),
  .acc_wdata_i  (acc_wdata_i),
  .irq_o        (irq_o),
  .ipb          (ipb_q),
  .pipr         (pipr),
  .cppr         (cppr_q),
  .ack_fire     (ack_fire)
);

// File: tb/os_irq_presenter_test.sv
module os_irq_presenter_test;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        notify = 1'b0;
  logic [2:0]  nprio = '0;
  logic        av = 1'b0, aw = 1'b0;
  logic [1:0]  apg = '0;
  logic [2:0]  asel = '0;
  logic [7:0]  awd = '0;
  logic [15:0] rdata;
  logic        irq;
  int n_chk = 0, n_bad = 0;
  bit  done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  os_irq_presenter uut (
    .clk_i(clk), .rst_ni(rst_n), .notify_i(notify), .notify_prio_i(nprio),
    .acc_valid_i(av), .acc_write_i(aw), .acc_page_i(apg), .acc_sel_i(asel),
    .acc_wdata_i(awd), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic send(logic [2:0] p);
    notify = 1'b1; nprio = p; step(); notify = 1'b0;
  endtask

  task automatic acc(logic w, logic [1:0] pg, logic [2:0] s, logic [7:0] d);
    av = 1'b1; aw = w; apg = pg; asel = s; awd = d; step();
    av = 1'b0; aw = 1'b0;
  endtask

  task automatic rd(logic [1:0] pg, logic [2:0] s, string req, logic [15:0] exp);
    acc(1'b0, pg, s, 8'h00);
    chk(req, rdata, exp);
  endtask

  task automatic t_reset();
    chk("R10 irq", {15'd0, irq}, 16'd0);
    chk("R10 rdata", rdata, 16'h0000);
    rd(2'b10, 3'd2, "R10 ipb", 16'h0000);
    rd(2'b10, 3'd1, "R10 cppr", 16'h0000);
    rd(2'b10, 3'd3, "R2 empty pipr", 16'h00FF);
    rd(2'b10, 3'd0, "R4 nsr idle", 16'h0000);
  endtask

  task automatic t_block();
    send(3'd5);
    idle(2);
    chk("R3 cppr0 blocks", {15'd0, irq}, 16'd0);
    rd(2'b10, 3'd2, "R1 ipb", 16'h0020);
    rd(2'b10, 3'd3, "R2 pipr", 16'h0005);
  endtask

  task automatic t_open();
    acc(1'b1, 2'b10, 3'd1, 8'hFF);
    chk("R5 not yet", {15'd0, irq}, 16'd0);
    idle(1);
    chk("R3 R5 raise", {15'd0, irq}, 16'd1);
    rd(2'b10, 3'd0, "R4 nsr eo", 16'h0080);
  endtask

  task automatic t_pages();
    acc(1'b1, 2'b11, 3'd1, 8'h00);
    idle(1);
    chk("R9 user store ignored", {15'd0, irq}, 16'd1);
    rd(2'b11, 3'd3, "R9 user reads zero", 16'h0000);
    acc(1'b1, 2'b01, 3'd1, 8'h00);
    rd(2'b01, 3'd1, "R8 hyp store ignored", 16'h00FF);
    rd(2'b00, 3'd2, "R8 phys read", 16'h0020);
    rd(2'b00, 3'd4, "R8 phys ack zero", 16'h0000);
    chk("R8 no ack effect", {15'd0, irq}, 16'd1);
    rd(2'b10, 3'd6, "R12 bad sel", 16'h0000);
  endtask

  task automatic t_ack();
    send(3'd2);
    idle(1);
    rd(2'b10, 3'd4, "R6 ack data", 16'h8002);
    chk("R6 irq drop", {15'd0, irq}, 16'd0);
    rd(2'b10, 3'd1, "R6 cppr", 16'h0002);
    rd(2'b10, 3'd2, "R6 ipb cleared", 16'h0020);
    chk("R6 stays low", {15'd0, irq}, 16'd0);
    rd(2'b10, 3'd4, "R7 idle ack", 16'h0005);
    rd(2'b10, 3'd1, "R7 cppr kept", 16'h0002);
    rd(2'b10, 3'd2, "R7 ipb kept", 16'h0020);
  endtask

  task automatic t_thresh();
    acc(1'b1, 2'b10, 3'd1, 8'h05); idle(1);
    chk("R3 equal no irq", {15'd0, irq}, 16'd0);
    acc(1'b1, 2'b10, 3'd1, 8'h06); idle(1);
    chk("R5 raise", {15'd0, irq}, 16'd1);
    acc(1'b1, 2'b10, 3'd1, 8'h03); idle(1);
    chk("R5 lower", {15'd0, irq}, 16'd0);
    acc(1'b1, 2'b10, 3'd1, 8'h06); idle(1);
    chk("R5 raise again", {15'd0, irq}, 16'd1);
  endtask

  task automatic t_collide();
    av = 1'b1; aw = 1'b0; apg = 2'b10; asel = 3'd4;
    notify = 1'b1; nprio = 3'd5;
    step();
    av = 1'b0; notify = 1'b0;
    chk("R11 ack data", rdata, 16'h8005);
    rd(2'b10, 3'd2, "R11 notify wins", 16'h0020);
    rd(2'b10, 3'd1, "R11 cppr", 16'h0005);
    chk("R11 irq low", {15'd0, irq}, 16'd0);
    send(3'd0); idle(1);
    chk("R3 prio0 raise", {15'd0, irq}, 16'd1);
    rd(2'b10, 3'd3, "R2 lowest", 16'h0000);
    rd(2'b10, 3'd2, "R1 two bits", 16'h0021);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle(2);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_block();
    t_open();
    t_pages();
    t_ack();
    t_thresh();
    t_collide();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule